// File: doc/BRIEF.md
# Physical Frame Bitmap Allocator

This block keeps track of which 4 KB frames of physical memory are free and which are in use. It holds one bit per frame; a frame's bit sits at the frame number, which is its physical address shifted right by 12. A clear bit means the frame is free and a set bit means it is in use. After reset the bitmap is loaded from two parameterised reserved frame ranges. A running count of free frames follows every change to the bitmap.

A client issues one command at a time with a valid/ready handshake. There are four commands: reserve a single frame, release a single frame, look up the lowest free frame, and allocate a contiguous block sized in bytes. The block answers each command with a one-cycle `done` pulse, carrying an error flag and a result address. For a block allocation, the byte count is rounded up to whole frames and checked against the free count before any search begins. The bitmap is then scanned upward one word per cycle, and the lowest-addressed run that fits is claimed.

Top module: `frame_bitmap_alloc`

## Requirements
- R1: After reset, frames RSV0_FIRST..RSV0_LAST and RSV1_FIRST..RSV1_LAST are in use and all others free (defaults 0..7 and 160..175 of 256, free count 232), `req_ready` is high and `done` is low.
- R2: Command code 0 (reserve) sets the bit of frame `req_addr>>12` and lowers the free count by one; `done` rises in the cycle right after acceptance, with `res_addr` 0.
- R3: Command code 1 (release) clears the bit of frame `req_addr>>12` and raises the free count by one.
- R4: Reserving a frame already in use, or releasing a frame already free, changes neither the bitmap nor the free count and reports no error.
- R5: A reserve or release whose frame number is not below NFRAMES reports an error and changes nothing.
- R6: Command code 2 (lookup) returns the address (frame number times 4096) of the lowest free frame and changes no bit; it reports an error when no frame is free.
- R7: Command code 3 (allocate) converts `req_bytes` to frames by rounding up to whole 4096-byte frames; a request of zero bytes is rejected with an error.
- R8: If the rounded frame count exceeds the free count, the allocate reports an error in the cycle right after acceptance and changes nothing.
- R9: A successful allocate claims the lowest-addressed run of contiguous free frames of the rounded length, lowers the free count by that length and returns the address of the run's first frame.
- R10: If the free count suffices but no contiguous run fits, the allocate reports an error and changes no bit and not the free count.
- R11: `err` is high only while `done` is high, and on every successful response `res_addr[11:0]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present |
| req_op | input | 2 | 0 reserve, 1 release, 2 lookup, 3 allocate |
| req_addr | input | 32 | Physical address of the frame for reserve/release |
| req_bytes | input | 32 | Byte count for allocate |
| req_ready | output | 1 | Block idle, command accepted when valid |
| done | output | 1 | One-cycle response strobe |
| err | output | 1 | Response is a rejection |
| res_addr | output | 32 | Result physical address |
| free_frames | output | 9 | Current number of free frames |

## Verification
The hardest situation to reach is R10: the free count must cover the request while no contiguous run fits. Random traffic seldom leaves memory fragmented in exactly that way. The stimulus therefore fills both free regions with two exact-size allocations, releases three non-adjacent frames, and asks for two frames. It then confirms through a lookup and the free count that nothing moved. Random reserve, release, lookup and allocate traffic, with a fixed seed, covers the rounding and run-placement cases against a bench bitmap model.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef enum logic [1:0] {
    OP_MARK  = 2'd0,
    OP_FREE  = 2'd1,
    OP_FIND  = 2'd2,
    OP_ALLOC = 2'd3
  } bpa_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } bpa_state_e;
endpackage

// File: rtl/bpa_need_calc.sv
module bpa_need_calc #(
  parameter int ADDR_W      = 32,
  parameter int FRAME_SHIFT = 12,
  localparam int NEED_W     = ADDR_W - FRAME_SHIFT + 1
) (
  input  logic [ADDR_W-1:0] bytes_in,
  output logic [NEED_W-1:0] frames_out
);
  // round up to whole frames
  always_comb begin
    frames_out = {1'b0, bytes_in[ADDR_W-1:FRAME_SHIFT]}
               + NEED_W'(|bytes_in[FRAME_SHIFT-1:0]);
  end
endmodule

// File: rtl/bpa_run_scan.sv
module bpa_run_scan #(
  parameter int WORD   = 32,
  parameter int WIDX_W = 3,
  parameter int CNT_W  = 9,
  localparam int BIT_W  = $clog2(WORD),
  localparam int FIDX_W = WIDX_W + BIT_W
) (
  input  logic [WORD-1:0]   bits,
  input  logic [WIDX_W-1:0] widx,
  input  logic [CNT_W-1:0]  run_in,
  input  logic [FIDX_W-1:0] start_in,
  input  logic [CNT_W-1:0]  need,
  output logic [CNT_W-1:0]  run_out,
  output logic [FIDX_W-1:0] start_out,
  output logic              hit,
  output logic [FIDX_W-1:0] hit_start
);
  always_comb begin
    logic [CNT_W-1:0]  run;
    logic [FIDX_W-1:0] st;
    run       = run_in;
    st        = start_in;
    hit       = 1'b0;
    hit_start = '0;
    for (int b = 0; b < WORD; b++) begin
      if (!hit) begin
        if (!bits[b]) begin
          if (run == '0) st = {widx, BIT_W'(b)};
          run = run + 1'b1;
          if (run == need) begin
            hit       = 1'b1;
            hit_start = st;
          end
        end else begin
          run = '0;
        end
      end
    end
    run_out   = run;
    start_out = st;
  end
endmodule

// File: rtl/frame_bitmap_alloc.sv
module frame_bitmap_alloc
  import bpa_pkg::*;
#(
  parameter int NFRAMES     = 256,
  parameter int WORD        = 32,
  parameter int ADDR_W      = 32,
  parameter int FRAME_SHIFT = 12,
  parameter int RSV0_FIRST  = 0,
  parameter int RSV0_LAST   = 7,
  parameter int RSV1_FIRST  = 160,
  parameter int RSV1_LAST   = 175,
  localparam int NWORDS = NFRAMES / WORD,
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int BIT_W  = $clog2(WORD),
  localparam int FIDX_W = WIDX_W + BIT_W,
  localparam int CNT_W  = $clog2(NFRAMES + 1),
  localparam int NEED_W = ADDR_W - FRAME_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_bytes,
  output logic              req_ready,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] res_addr,
  output logic [CNT_W-1:0]  free_frames
);
  function automatic logic rsv_bit(int i);
    return (i >= RSV0_FIRST && i <= RSV0_LAST) || (i >= RSV1_FIRST && i <= RSV1_LAST);
  endfunction

  function automatic int init_free();
    int n = 0;
    for (int i = 0; i < NFRAMES; i++) if (!rsv_bit(i)) n++;
    return n;
  endfunction

  localparam int INIT_FREE = init_free();

  logic [WORD-1:0]   bm [NWORDS];
  bpa_state_e        st;
  bpa_op_e           op_q;
  logic [CNT_W-1:0]  need_q, run_q, run_n;
  logic [FIDX_W-1:0] start_q, start_n, hit_start;
  logic [WIDX_W-1:0] widx_q;
  logic              hit;
  logic [NEED_W-1:0] need_w;

  bpa_op_e           op_in;
  logic [ADDR_W-FRAME_SHIFT-1:0] frame_hi;
  logic              frame_ok;
  logic [FIDX_W-1:0] frame_idx;
  logic [WIDX_W-1:0] fw;
  logic [BIT_W-1:0]  fb;
  logic [FRAME_SHIFT-1:0] addr_unused;

  assign op_in       = bpa_op_e'(req_op);
  assign frame_hi    = req_addr[ADDR_W-1:FRAME_SHIFT];
  assign addr_unused = req_addr[FRAME_SHIFT-1:0];
  assign frame_ok    = frame_hi < (ADDR_W-FRAME_SHIFT)'(NFRAMES);
  assign frame_idx   = frame_hi[FIDX_W-1:0];
  assign fw          = frame_idx[FIDX_W-1:BIT_W];
  assign fb          = frame_idx[BIT_W-1:0];
  assign req_ready   = (st == ST_IDLE);

  bpa_need_calc #(.ADDR_W(ADDR_W), .FRAME_SHIFT(FRAME_SHIFT)) u_need (
    .bytes_in(req_bytes), .frames_out(need_w)
  );

  bpa_run_scan #(.WORD(WORD), .WIDX_W(WIDX_W), .CNT_W(CNT_W)) u_scan (
    .bits(bm[widx_q]), .widx(widx_q), .run_in(run_q), .start_in(start_q),
    .need(need_q), .run_out(run_n), .start_out(start_n),
    .hit(hit), .hit_start(hit_start)
  );

  // bitmap storage and its reset image
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NWORDS; w++)
        for (int b = 0; b < WORD; b++)
          bm[w][b] <= rsv_bit(w * WORD + b);
    end else if (st == ST_IDLE && req_valid && frame_ok) begin
      if (op_in == OP_MARK)      bm[fw][fb] <= 1'b1;
      else if (op_in == OP_FREE) bm[fw][fb] <= 1'b0;
    end else if (st == ST_SCAN && hit && op_q == OP_ALLOC) begin
      for (int w = 0; w < NWORDS; w++)
        for (int b = 0; b < WORD; b++)
          if ((w * WORD + b) >= int'(hit_start) &&
              (w * WORD + b) <  int'(hit_start) + int'(need_q))
            bm[w][b] <= 1'b1;
    end
  end

  // control, counter and registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      op_q        <= OP_MARK;
      need_q      <= '0;
      run_q       <= '0;
      start_q     <= '0;
      widx_q      <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      res_addr    <= '0;
      free_frames <= CNT_W'(INIT_FREE);
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      res_addr <= '0;
      if (st == ST_IDLE) begin
        if (req_valid) begin
          op_q    <= op_in;
          run_q   <= '0;
          start_q <= '0;
          widx_q  <= '0;
          case (op_in)
            OP_MARK, OP_FREE: begin
              done <= 1'b1;
              err  <= !frame_ok;
              if (frame_ok && op_in == OP_MARK && !bm[fw][fb])
                free_frames <= free_frames - 1'b1;
              if (frame_ok && op_in == OP_FREE && bm[fw][fb])
                free_frames <= free_frames + 1'b1;
            end
            OP_FIND: begin
              need_q <= CNT_W'(1);
              st     <= ST_SCAN;
            end
            default: begin
              if (need_w == '0 || need_w > NEED_W'(free_frames)) begin
                done <= 1'b1;
                err  <= 1'b1;
              end else begin
                need_q <= CNT_W'(need_w);
                st     <= ST_SCAN;
              end
            end
          endcase
        end
      end else begin
        run_q   <= run_n;
        start_q <= start_n;
        widx_q  <= widx_q + 1'b1;
        if (hit) begin
          done     <= 1'b1;
          res_addr <= ADDR_W'(hit_start) << FRAME_SHIFT;
          st       <= ST_IDLE;
          if (op_q == OP_ALLOC) free_frames <= free_frames - need_q;
        end else if (widx_q == WIDX_W'(NWORDS - 1)) begin
          done <= 1'b1;
          err  <= 1'b1;
          st   <= ST_IDLE;
        end
      end
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    free_frames <= CNT_W'(NFRAMES));
  // R11
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R11
  res_align_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> res_addr[FRAME_SHIFT-1:0] == '0);
  // R8 R10
  fail_keeps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> free_frames == $past(free_frames));
  // R6
  find_keeps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_FIND) |-> $stable(free_frames));
  // R9
  scan_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SCAN && hit) |-> int'(hit_start) + int'(need_q) <= NFRAMES);
endmodule

// File: tb/frame_bitmap_alloc_bench.sv
module frame_bitmap_alloc_bench;
  localparam int NF = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_bytes = '0;
  logic        req_ready, done, err;
  logic [31:0] res_addr;
  logic [8:0]  free_frames;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic mbm [NF];
  int   mcnt;
  logic e_err;
  logic [31:0] e_res;
  int   lat;

  frame_bitmap_alloc u_frame_bitmap_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_ready(req_ready),
    .done(done), .err(err), .res_addr(res_addr), .free_frames(free_frames)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    mcnt = 0;
    for (int i = 0; i < NF; i++) begin
      mbm[i] = (i <= 7) || (i >= 160 && i <= 175);
      if (!mbm[i]) mcnt++;
    end
  endfunction

  // expected response and model update
  function automatic void model_op(input logic [1:0] op, input logic [31:0] addr,
                                   input logic [31:0] bytes);
    longint fr = addr >> 12;
    longint need = (longint'(bytes) + 4095) / 4096;
    int run = 0;
    int st = 0;
    int found = -1;
    e_err = 1'b0;
    e_res = '0;
    if (op < 2) begin
      if (fr >= NF) e_err = 1'b1;
      else if (op == 0 && !mbm[fr]) begin mbm[fr] = 1'b1; mcnt--; end
      else if (op == 1 && mbm[fr]) begin mbm[fr] = 1'b0; mcnt++; end
    end else begin
      if (op == 2) need = 1;
      if (need == 0 || need > mcnt) begin
        e_err = 1'b1;
      end else begin
        for (int i = 0; i < NF && found < 0; i++) begin
          if (!mbm[i]) begin
            if (run == 0) st = i;
            run++;
            if (run == need) found = st;
          end else run = 0;
        end
        if (found < 0) e_err = 1'b1;
        else begin
          e_res = 32'(found) << 12;
          if (op == 3) begin
            for (int i = found; i < found + int'(need); i++) mbm[i] = 1'b1;
            mcnt -= int'(need);
          end
        end
      end
    end
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [31:0] addr,
                       input logic [31:0] bytes, input string tag);
    model_op(op, addr, bytes);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_bytes = bytes;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(done == 1'b1, {tag, " done"}, done, 1);
    chk(err == e_err, {tag, " err"}, err, e_err);
    chk(res_addr == e_res, {tag, " res_addr"}, res_addr, e_res);
    chk(free_frames == 9'(mcnt), {tag, " free_frames"}, free_frames, mcnt);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(free_frames == 9'd232, "R1 free count", free_frames, 232);
    do_op(2'd2, 0, 0, "R1 R6 lowest free after reset");
    // R2 reserve, one-cycle response
    do_op(2'd0, 32'h0000_8abc, 0, "R2 reserve frame 8");
    chk(lat == 0, "R2 latency", lat, 0);
    do_op(2'd2, 0, 0, "R6 lookup skips reserved");
    // R4 repeat reserve, release already-free
    do_op(2'd0, 32'h0000_8000, 0, "R4 reserve twice");
    do_op(2'd1, 32'h0001_0000, 0, "R4 release free frame");
    // R3 release
    do_op(2'd1, 32'h0000_8000, 0, "R3 release frame 8");
    // R5 out of range
    do_op(2'd0, 32'h0010_0000, 0, "R5 reserve beyond range");
    do_op(2'd1, 32'hffff_f000, 0, "R5 release beyond range");
    // R7 rounding and zero
    do_op(2'd3, 32'd0, 0, "R7 zero bytes");
    do_op(2'd3, 0, 32'd4096, "R7 exact frame");
    do_op(2'd3, 0, 32'd4097, "R7 round up to two");
    do_op(2'd3, 0, 32'd1, "R7 one byte");
    // R8 too large
    do_op(2'd3, 0, 32'h0100_0000, "R8 exceeds free count");
    chk(lat == 0, "R8 latency", lat, 0);
    // R9 / R10 fragmentation: fill both regions, free scattered frames
    do_op(2'd1, 32'h0000_8000, 0, "R3 release");
    do_op(2'd1, 32'h0000_9000, 0, "R3 release");
    do_op(2'd1, 32'h0000_a000, 0, "R3 release");
    do_op(2'd1, 32'h0000_b000, 0, "R3 release");
    do_op(2'd3, 0, 32'(152 * 4096), "R9 fill low region");
    do_op(2'd3, 0, 32'(80 * 4096), "R9 fill high region");
    do_op(2'd2, 0, 0, "R6 lookup when full");
    do_op(2'd1, 32'h0000_a000, 0, "R3 release 10");
    do_op(2'd1, 32'h0000_c000, 0, "R3 release 12");
    do_op(2'd1, 32'h0000_e000, 0, "R3 release 14");
    do_op(2'd3, 0, 32'd8192, "R10 no contiguous run");
    do_op(2'd2, 0, 32'd0, "R10 bitmap unchanged");
    do_op(2'd3, 0, 32'd4000, "R9 single frame lowest");
    // random traffic
    for (int k = 0; k < 600; k++) begin
      int sel = int'($urandom_range(0, 9));
      logic [31:0] a = ($urandom_range(0, NF + 15) << 12) | $urandom_range(0, 4095);
      logic [31:0] b = $urandom_range(0, 24 * 4096);
      if (sel < 3)       do_op(2'd0, a, 0, "R2 random reserve");
      else if (sel < 7)  do_op(2'd1, a, 0, "R3 random release");
      else if (sel < 8)  do_op(2'd2, 0, 0, "R6 random lookup");
      else               do_op(2'd3, 0, b, "R9 random allocate");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule